// File: doc/BRIEF.md
# Timestamp event queue with pending interrupt

This block buffers captured time-stamp events until software reads them. Each event is a 64-bit record. Software sees the oldest record as two 32-bit words, a low half and a high half. It reads both words and then removes the record with a one-cycle pop strobe. Push, pop and status all run on one clock.

A raw pending flag is high whenever the queue holds at least one record. An enable input gates that flag onto the interrupt line. Software can use the interrupt and drain several records in one service routine. It does this by popping, waiting a short settle time and sampling the raw flag again. It can also leave the interrupt disabled and poll the raw flag.

The queue holds a parameterised number of records, 16 by default. A record pushed while the queue is full is dropped, and a sticky overflow flag is raised. The flag clears only on reset.

Top module: `ts_evt_queue`

## Requirements
- R1: After reset the queue is empty: pend_raw_o, irq_o, full_o and overflow_o are 0, and both event words read 0.
- R2: evt_lo_o carries bits 31:0 and evt_hi_o carries bits 63:32 of the oldest record still queued. Records leave in the order they were pushed.
- R3: A pop strobe on a non-empty queue removes the head record. The next record is shown on the words from the cycle after the pop edge.
- R4: pend_raw_o equals "queue non-empty". It rises in the cycle after a push into an empty queue and falls in the cycle after the edge that pops the last record. It is therefore valid one cycle after any pop, well inside an eight-cycle settle window.
- R5: irq_o is pend_raw_o ANDed with int_en_i, and it follows int_en_i in the same cycle.
- R6: full_o is 1 exactly when DEPTH records are queued.
- R7: A push while the queue is full and not popping is dropped. It sets overflow_o, which stays 1 until reset, and the queued contents are unchanged.
- R8: A pop on an empty queue is ignored. The read position does not move, so a later push is read back correctly.
- R9: While the queue is empty, both event words read 0.
- R10: A push and a pop in the same cycle on a non-empty queue both take effect, and the record count is unchanged. This applies even when the queue is full, in which case the push is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push strobe for a captured event |
| push_evt_i | input | 64 | Event record to push |
| pop_i | input | 1 | Pop strobe from software |
| int_en_i | input | 1 | Interrupt enable |
| evt_lo_o | output | 32 | Low word of the head record |
| evt_hi_o | output | 32 | High word of the head record |
| pend_raw_o | output | 1 | Raw pending status |
| irq_o | output | 1 | Gated interrupt |
| full_o | output | 1 | Queue full |
| overflow_o | output | 1 | Sticky dropped-event flag |

## Verification
The bench goes after several corner cases, each paired here with the fault it would expose.

- **Full-queue push:** a design that accepted this push would overwrite the head or wrap the count to empty. That shows up as wrong words or a low pending flag.
- **Pop on an empty queue:** a design that moved the read position anyway would return stale data after the next push.
- **Push and pop together:** this is driven both mid-queue and at full. A design that gave one side priority would drift its count, lose a record, or raise overflow falsely.
- **Empty-queue reads and pending edges:** the bench checks that the words read zero and that pending flips in exactly the cycle after the edge. A late flag or leftover data fails these checks.

// File: rtl/ts_evt_pkg.sv
package ts_evt_pkg;
  parameter int unsigned EVT_W = 64;
  parameter int unsigned WORD_W = EVT_W / 2;
  typedef logic [EVT_W-1:0] evt_t;
endpackage

// File: rtl/ts_evt_store.sv
module ts_evt_store
  import ts_evt_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_ptr_i,
  input  evt_t          wr_evt_i,
  input  logic [AW-1:0] rd_ptr_i,
  output evt_t          rd_evt_o
);
  evt_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_i] <= wr_evt_i;
  end

  assign rd_evt_o = mem_q[rd_ptr_i];
endmodule

// File: rtl/ts_evt_ctrl.sv
module ts_evt_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          overflow_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_P  = AW'(DEPTH - 1);

  logic [CW-1:0] cnt_q;
  logic [AW-1:0] wr_q, rd_q;
  logic          ovf_q;
  logic          pop_ok, push_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == DEPTH_C);
  assign pop_ok  = pop_i && !empty_o;
  // a pop in the same cycle frees a slot for the push
  assign push_ok = push_i && (!full_o || pop_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push_ok) wr_q <= (wr_q == LAST_P) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == LAST_P) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push_i && !push_ok) ovf_q <= 1'b1;
    end
  end

  assign wr_en_o    = push_ok;
  assign wr_ptr_o   = wr_q;
  assign rd_ptr_o   = rd_q;
  assign overflow_o = ovf_q;

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DEPTH_C);
  // R8
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o) |=> $stable(rd_q));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  // R7
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (full_o && ovf_q && $stable(wr_q)));
  // R10
  both_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !empty_o) |=> $stable(cnt_q));
endmodule

// File: rtl/ts_evt_queue.sv
module ts_evt_queue
  import ts_evt_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [EVT_W-1:0]  push_evt_i,
  input  logic              pop_i,
  input  logic              int_en_i,
  output logic [WORD_W-1:0] evt_lo_o,
  output logic [WORD_W-1:0] evt_hi_o,
  output logic              pend_raw_o,
  output logic              irq_o,
  output logic              full_o,
  output logic              overflow_o
);
  logic          wr_en, empty;
  logic [AW-1:0] wr_ptr, rd_ptr;
  evt_t          head;

  ts_evt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .wr_en_o   (wr_en),
    .wr_ptr_o  (wr_ptr),
    .rd_ptr_o  (rd_ptr),
    .empty_o   (empty),
    .full_o    (full_o),
    .overflow_o(overflow_o)
  );

  ts_evt_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .wr_en_i (wr_en),
    .wr_ptr_i(wr_ptr),
    .wr_evt_i(push_evt_i),
    .rd_ptr_i(rd_ptr),
    .rd_evt_o(head)
  );

  assign pend_raw_o = !empty;
  assign irq_o      = pend_raw_o && int_en_i;
  assign evt_lo_o   = empty ? '0 : head[WORD_W-1:0];
  assign evt_hi_o   = empty ? '0 : head[EVT_W-1:WORD_W];

  // R4
  pend_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pend_raw_o) |=> pend_raw_o);
  // R9
  empty_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_raw_o |-> (evt_lo_o == '0 && evt_hi_o == '0));
endmodule

// File: tb/ts_evt_queue_tb.sv
module ts_evt_queue_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push = 1'b0, pop = 1'b0, int_en = 1'b0;
  logic [63:0] push_evt = '0;
  logic [31:0] evt_lo, evt_hi;
  logic        pend, irq, full, ovf;

  int total = 0, bad = 0;
  bit done = 0;

  logic [63:0] mq [DEPTH];
  int          m_head = 0, m_cnt = 0;
  bit          m_ovf = 0;
  string       data_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_evt_queue #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_evt_i(push_evt),
    .pop_i(pop), .int_en_i(int_en), .evt_lo_o(evt_lo), .evt_hi_o(evt_hi),
    .pend_raw_o(pend), .irq_o(irq), .full_o(full), .overflow_o(ovf)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_head();
    return (m_cnt == 0) ? 64'd0 : mq[m_head];
  endfunction

  // call at negedge: check state, drive, check irq, advance model
  task automatic step(bit ps, logic [63:0] d, bit pp, bit en);
    bit pop_ok, push_ok;
    chk((m_cnt == 0) ? "R9" : data_tag, {evt_hi, evt_lo}, exp_head());
    chk("R4", 64'(pend), 64'(m_cnt != 0));
    chk("R6", 64'(full), 64'(m_cnt == DEPTH));
    chk("R7", 64'(ovf), 64'(m_ovf));
    push = ps; push_evt = d; pop = pp; int_en = en;
    #1;
    chk("R5", 64'(irq), 64'((m_cnt != 0) && en));
    pop_ok  = pp && (m_cnt != 0);
    push_ok = ps && ((m_cnt != DEPTH) || pop_ok);
    data_tag = pop_ok ? (push_ok ? "R10" : "R3") : (pp ? "R8" : "R2");
    if (ps && !push_ok) m_ovf = 1;
    if (push_ok) mq[(m_head + m_cnt) % DEPTH] = d;
    if (pop_ok) begin m_head = (m_head + 1) % DEPTH; m_cnt--; end
    if (push_ok) m_cnt++;
    @(negedge clk);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 2);
    @(negedge clk);
    // R1: reset state
    chk("R1", {evt_hi, evt_lo}, 64'd0);
    chk("R1", {60'd0, pend, irq, full, ovf}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: pop on empty, then push and read back
    step(0, 0, 1, 1);
    step(1, 64'hA5A5_0001_DEAD_BEEF, 0, 1);
    step(0, 0, 0, 0);
    step(0, 0, 1, 1);
    // R6/R7: fill, overflow, then push+pop at full (R10)
    for (int i = 0; i < DEPTH; i++) step(1, 64'(i) * 64'h0101_0101_0101_0101 + 64'd7, 0, 1);
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1);
    step(1, 64'h1111_2222_3333_4444, 1, 1);
    step(0, 0, 0, 0);
    // R3/R2: drain fully
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 1, i[0]);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      step(r < 55, rnd64(), (r % 3) == 0, $urandom_range(0, 1) == 1);
    end
    step(0, 0, 0, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule